// File: doc/BRIEF.md
# Serial Control-Word Loader

This block receives control words over a three-wire, write-only serial link made of a bit clock, a data line and a load strobe. Bits are taken on each rising edge of the bit clock while the strobe is low, most significant bit first, into a 32-bit shift register. A rising edge on the strobe commits the collected word. The word's three lowest bits name one of eight holding registers, and the whole word, address bits included, is copied into that register.

All eight holding registers drive a flat parallel output bus. A one-hot write pulse lasting one system clock marks which register was just updated. The three serial lines are asynchronous to the system clock and pass through two-flop synchronisers before any edge is detected. The system clock must therefore run at least four times faster than the bit clock.

If the number of bit-clock edges since the previous commit is not exactly 32, the last 32 bits shifted are still committed, and a sticky error flag is raised.

Top module: `serreg_loader`

## Requirements
- R1: While reset is asserted and after it is released, every holding register reads zero, the write pulse is all zero and the error flag is low.
- R2: A bit is sampled on each rising bit-clock edge while the strobe is low, entering at bit 0 of the shift register, so the first bit sent ends up in bit 31.
- R3: On a strobe rising edge, the shift register value is stored whole in the holding register whose index equals its bits 2..0. Holding register i occupies bits 32*i+31 down to 32*i of the output bus.
- R4: Each strobe rising edge produces exactly one write-pulse cycle. In that cycle, only bit i of the pulse is set, where i is the committed address.
- R5: Holding registers that are not addressed keep their values across a commit.
- R6: Bit-clock edges that occur while the strobe is high neither shift data nor count toward the bit total.
- R7: A commit preceded by fewer or more than 32 sampled edges still stores the last 32 bits shifted and sets the error flag.
- R8: Once set, the error flag stays high until reset, including across later correct commits.
- R9: Updates to the registers and the write pulse appear on the third system-clock edge after the strobe pin rises: two synchroniser stages, then one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| sle_i | input | 1 | Load strobe; a rising edge commits the word |
| regs_o | output | 256 | Eight 32-bit holding registers, register i at bits 32*i+31 down to 32*i |
| wr_pulse_o | output | 8 | One-hot, one-cycle update marker |
| cnt_err_o | output | 1 | Sticky bit-count error flag |

## Verification
The properties assume that the strobe stays low for several system clocks between commits, so a write pulse never repeats in back-to-back cycles. They also assume that no bit-clock edge coincides with a strobe edge. The stimulus holds every serial level for four system clocks. Data changes two system clocks before each bit-clock rise and holds until two after the fall. The strobe is raised only after the bit clock has been low for several cycles, and is held for six cycles. These conditions keep all synchronised signals aligned and edges well separated.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 3;
  localparam int unsigned SYNC_N_DEF = 2;
  // index of each serial line inside the synchroniser vector
  localparam int unsigned LN_CLK = 0;
  localparam int unsigned LN_DAT = 1;
  localparam int unsigned LN_LE  = 2;
  localparam int unsigned LN_NUM = 3;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_rise_i,
  input  logic         dat_i,
  input  logic         le_lvl_i,
  input  logic         le_rise_i,
  output logic [W-1:0] word_o,
  output logic         err_o
);
  localparam int unsigned CW = $clog2(W + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);
  localparam logic [CW-1:0] CNT_SAT  = '1;

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          sh_en;

  assign sh_en = bit_rise_i & ~le_lvl_i & ~le_rise_i;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    err_d = err_q;
    if (le_rise_i) begin
      cnt_d = '0;
      if (cnt_q != CNT_FULL) err_d = 1'b1;
    end else if (sh_en) begin
      sh_d = {sh_q[W-2:0], dat_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign word_o = sh_q;
  assign err_o  = err_q;
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic [W-1:0]             word_i,
  output logic [(1<<AW)*W-1:0]     regs_o,
  output logic [(1<<AW)-1:0]       pulse_o
);
  localparam int unsigned NREG = 1 << AW;

  logic [AW-1:0]   addr;
  logic [NREG-1:0] sel;
  logic [NREG-1:0] pulse_q;

  assign addr = word_i[AW-1:0];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [W-1:0] hold_q, hold_d;
      assign sel[i] = commit_i && (addr == AW'(i));
      always_comb begin
        hold_d = hold_q;
        if (sel[i]) hold_d = word_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hold_q <= '0;
        else         hold_q <= hold_d;
      end
      assign regs_o[i*W +: W] = hold_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= '0;
    else         pulse_q <= sel;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/serreg_loader.sv
module serreg_loader
  import serreg_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sclk_i,
  input  logic                          sdat_i,
  input  logic                          sle_i,
  output logic [(1<<ADDR_W)*WORD_W-1:0] regs_o,
  output logic [(1<<ADDR_W)-1:0]        wr_pulse_o,
  output logic                          cnt_err_o
);
  logic [LN_NUM-1:0] raw, lvl, rise;
  logic [WORD_W-1:0] word;

  always_comb begin
    raw         = '0;
    raw[LN_CLK] = sclk_i;
    raw[LN_DAT] = sdat_i;
    raw[LN_LE]  = sle_i;
  end

  serreg_sync #(.W(LN_NUM), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  serreg_shifter #(.W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_rise_i (rise[LN_CLK]),
    .dat_i      (lvl[LN_DAT]),
    .le_lvl_i   (lvl[LN_LE]),
    .le_rise_i  (rise[LN_LE]),
    .word_o     (word),
    .err_o      (cnt_err_o)
  );

  serreg_bank #(.W(WORD_W), .AW(ADDR_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (rise[LN_LE]),
    .word_i   (word),
    .regs_o   (regs_o),
    .pulse_o  (wr_pulse_o)
  );
endmodule

// File: rtl/serreg_chk.sv
module serreg_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [(1<<ADDR_W)*WORD_W-1:0] regs_o,
  input logic [(1<<ADDR_W)-1:0]        wr_pulse_o,
  input logic                          cnt_err_o
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_zero_chk: assert (regs_o == '0 && wr_pulse_o == '0 && !cnt_err_o);
    end
  end

  // R4
  pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_pulse_o));

  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse_o != '0) |=> (wr_pulse_o == '0));

  // R5
  regs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> (wr_pulse_o != '0));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_err_o |=> cnt_err_o);
endmodule

bind serreg_loader serreg_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .regs_o     (regs_o),
  .wr_pulse_o (wr_pulse_o),
  .cnt_err_o  (cnt_err_o)
);

// File: tb/sim_serreg_loader.sv
module sim_serreg_loader;
  localparam int CLK_PER = 10;
  localparam int W  = 32;
  localparam int NR = 8;

  logic clk, rst_n, sclk, sdat, sle;
  logic [NR*W-1:0] regs;
  logic [NR-1:0]   pulse;
  logic            err;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_sr;
  logic [W-1:0] m_reg [NR];
  int           m_cnt;
  logic         m_err;

  serreg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sle_i(sle),
    .regs_o(regs), .wr_pulse_o(pulse), .cnt_err_o(err)
  );

  initial clk = 0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit model);
    @(negedge clk) sdat = b;
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
    repeat (2) @(negedge clk);
    if (model) begin
      m_sr = {m_sr[W-2:0], b};
      m_cnt++;
    end
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) send_bit(v[k], 1'b1);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NR; i++)
      chk(regs[i*W +: W] === m_reg[i], req, regs[i*W +: W], m_reg[i]);
    chk(err === m_err, "R7/R8 err", {31'd0, err}, {31'd0, m_err});
  endtask

  // raise the strobe, watch the pulse, optionally toggle sclk while high
  task automatic commit(input int extra);
    int hits;
    int a;
    hits = 0;
    a = int'(m_sr[2:0]);
    repeat (2) @(negedge clk);
    sle = 1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (pulse != '0) hits++;
      if (k == 3) chk(pulse === NR'(1 << a), "R4/R9 pulse at third edge", W'(pulse), W'(1 << a));
    end
    chk(hits == 1, "R4 one pulse cycle", W'(hits), 1);
    m_reg[a] = m_sr;
    if (m_cnt != W) m_err = 1'b1;
    m_cnt = 0;
    for (int e = 0; e < extra; e++) send_bit(1'b1, 1'b0); // R6: ignored
    sle = 0;
    repeat (4) @(negedge clk);
    check_all("R2/R3/R5 regs");
  endtask

  function automatic logic [W-1:0] pat(input int a, input int seed);
    logic [W-1:0] w;
    w = W'(32'h9E3779B9 * (a + 3 + seed)) ^ W'(seed * 32'h01010101);
    w[2:0] = 3'(a);
    return w;
  endfunction

  initial begin
    rst_n = 0; sclk = 0; sdat = 0; sle = 0;
    m_sr = '0; m_cnt = 0; m_err = 0;
    for (int i = 0; i < NR; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(regs === '0 && pulse === '0 && err === 1'b0, "R1 reset", W'(pulse), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // sweep all addresses, full words
    for (int a = 0; a < NR; a++) begin
      send_bits({32'd0, pat(a, 0)}, W);
      commit(0);
    end
    // R6: clocks while strobe high, then a full word must not flag error
    send_bits({32'd0, pat(5, 7)}, W);
    commit(3);
    send_bits({32'd0, pat(2, 9)}, W);
    commit(0);
    chk(err === 1'b0, "R6 no count while strobe high", {31'd0, err}, 0);

    // R7 short word
    send_bits({44'd0, 20'hA5C3E}, 20);
    commit(0);
    chk(err === 1'b1, "R7 short word error", {31'd0, err}, 1);
    // R7 long word
    send_bits({24'd0, 40'hF0_1234_5676}, 40);
    commit(0);
    // R7 empty commit
    commit(0);
    // R8 err stays after good words, inverted sweep
    for (int a = NR - 1; a >= 0; a--) begin
      send_bits({32'd0, ~pat(a, 1) ^ 32'h7}, W);
      commit(0);
    end
    chk(err === 1'b1, "R8 sticky", {31'd0, err}, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule